// File: doc/BRIEF.md
# DRAM Auto-Refresh Scheduler

This block keeps a DDR2-style SDRAM refreshed on behalf of a memory controller. A free-running interval timer adds one owed refresh to a pending count each time it expires. While anything is owed, the block raises a request to the controller's command arbiter. Once the arbiter grants the command bus, the block runs a fixed sequence. If the arbiter reports any open bank, it first issues a precharge of all banks with address bit 10 high and waits out the precharge recovery time. It then issues REFRESH and holds the bus with NOPs for the whole refresh cycle time. At the end it pulses a completion strobe and releases the bus.

The interval length depends on a temperature flag. Above +85 °C the reload value is roughly half the normal one. The flag is sampled whenever the timer reloads. Up to eight refreshes may be owed while the arbiter is busy with other traffic. At that limit the request is marked urgent, and any further expiries are not counted. Each finished refresh reduces the owed count by one. Refreshes that are still owed therefore run back to back, one full refresh cycle apart.

Top module: `ref_sched`

## Requirements
- R1: While reset is high and on the cycle after it, cmd_o is NOP (2'b00), a10_o, req_o, urgent_o, busy_o and done_o are low, and cke_o is high.
- R2: With hot_i low, the timer expires every TREFI_NORM cycles; the first expiry after reset release sets req_o high exactly TREFI_NORM rising edges later.
- R3: If hot_i is high on the cycle the timer expires, the following interval is TREFI_HOT cycles instead.
- R4: If req_o is high, busy_o is low and gnt_i is high, with bank_open_i low, cmd_o shows REF (2'b10) on the next cycle and busy_o rises.
- R5: Under the same condition with bank_open_i high, cmd_o shows PRE (2'b01) with a10_o high on the next cycle, and REF follows exactly T_RP cycles after the PRE.
- R6: After a REF, cmd_o stays NOP for T_RFC-1 cycles. done_o is high for one cycle, the last of these, and busy_o falls on the next cycle.
- R7: Each timer expiry adds one to the owed count, which stops at MAX_PEND. urgent_o is high exactly while the count equals MAX_PEND.
- R8: Each done_o pulse removes one owed refresh, and req_o falls when none remain. Consecutive REF commands are at least T_RFC cycles apart.
- R9: cke_o is high on every cycle.
- R10: gnt_i has no effect while nothing is owed: cmd_o stays NOP and busy_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| hot_i | input | 1 | Case temperature above +85 °C |
| bank_open_i | input | 1 | At least one bank is active (sampled at grant) |
| gnt_i | input | 1 | Arbiter grants the command bus |
| req_o | output | 1 | At least one refresh is owed |
| urgent_o | output | 1 | Owed count at its limit |
| busy_o | output | 1 | Block holds the command bus |
| done_o | output | 1 | One-cycle strobe at the end of the refresh cycle time |
| cmd_o | output | 2 | Command: 00 NOP, 01 PRE, 10 REF |
| a10_o | output | 1 | Address bit 10 (high on precharge-all) |
| cke_o | output | 1 | Clock enable |

## Verification
Four rules are checked by assertions on every cycle: no command other than NOP appears within T_RFC of a REF, REF never comes sooner than T_RP after a PRE, the owed count never exceeds its limit or drops below zero, and done_o and timer expiries never last two cycles. The exact interval lengths under each temperature setting, the choice between PRE and a direct REF, saturation and urgency under a long-stalled arbiter, and the draining of owed refreshes back to back can only be shown by the bench. It runs a cycle-level model of these rules against random grants, bank states and temperature changes.

// File: rtl/ref_pkg.sv
`timescale 1ns/1ps
package ref_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_PRE = 2'b01,
        CMD_REF = 2'b10
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_RP,
        ST_REF,
        ST_RFC
    } seq_e;

    typedef struct packed {
        cmd_e op;
        logic a10;
    } bus_t;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic bus_t bus_for(seq_e s);
        bus_t b;
        b.op  = CMD_NOP;
        b.a10 = 1'b0;
        case (s)
            ST_PRE: begin
                b.op  = CMD_PRE;
                b.a10 = 1'b1;
            end
            ST_REF:  b.op = CMD_REF;
            default: b.op = CMD_NOP;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/ref_tick.sv
`timescale 1ns/1ps
module ref_tick
    import ref_pkg::*;
#(
    parameter int NORM = 1950,
    parameter int HOT  = 975
) (
    input  logic clk,
    input  logic rst,
    input  logic hot_i,
    output logic tick_o
);
    localparam int W = $clog2(max2(NORM, HOT) + 1);

    logic [W-1:0] cnt;
    logic [W-1:0] reload;

    assign reload = hot_i ? W'(HOT - 1) : W'(NORM - 1);
    assign tick_o = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= W'(NORM - 1);
        else if (cnt == '0)
            cnt <= reload;
        else
            cnt <= cnt - 1'b1;
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o); // R2
endmodule

// File: rtl/ref_pend.sv
`timescale 1ns/1ps
module ref_pend #(
    parameter int MAXP = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic inc_i,
    input  logic dec_i,
    output logic nz_o,
    output logic full_o
);
    localparam int PW = $clog2(MAXP + 1);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case ({inc_i, dec_i})
                2'b10:   if (cnt != PW'(MAXP)) cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign nz_o   = (cnt != '0);
    assign full_o = (cnt == PW'(MAXP));

    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= MAXP); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        dec_i |-> (cnt != '0)); // R8
endmodule

// File: rtl/ref_seq.sv
`timescale 1ns/1ps
module ref_seq
    import ref_pkg::*;
#(
    parameter int TRP  = 4,
    parameter int TRFC = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic owed_i,
    input  logic gnt_i,
    input  logic bank_open_i,
    output bus_t bus_o,
    output logic busy_o,
    output logic done_o
);
    localparam int SMAX = max2(TRP, TRFC);
    localparam int WW   = $clog2(SMAX + 1);

    seq_e          st;
    logic [WW-1:0] wcnt;
    logic          start;

    assign start  = (st == ST_IDLE) && gnt_i && owed_i;
    assign bus_o  = bus_for(st);
    assign busy_o = (st != ST_IDLE);
    assign done_o = (st == ST_RFC) && (wcnt == WW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            wcnt <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) st <= bank_open_i ? ST_PRE : ST_REF;
                ST_PRE: begin
                    st   <= ST_RP;
                    wcnt <= WW'(TRP - 1);
                end
                ST_RP: begin
                    if (wcnt == WW'(1)) st <= ST_REF;
                    else                wcnt <= wcnt - 1'b1;
                end
                ST_REF: begin
                    st   <= ST_RFC;
                    wcnt <= WW'(TRFC - 1);
                end
                ST_RFC: begin
                    if (wcnt == WW'(1)) st <= ST_IDLE;
                    else                wcnt <= wcnt - 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // spacing monitors for the timing assertions
    logic [WW:0] since_ref;
    logic [WW:0] since_pre;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_ref <= (WW+1)'(SMAX);
            since_pre <= (WW+1)'(SMAX);
        end else begin
            if (bus_o.op == CMD_REF)              since_ref <= (WW+1)'(1);
            else if (int'(since_ref) < SMAX)      since_ref <= since_ref + 1'b1;
            if (bus_o.op == CMD_PRE)              since_pre <= (WW+1)'(1);
            else if (int'(since_pre) < SMAX)      since_pre <= since_pre + 1'b1;
        end
    end

    AST_RFC_QUIET: assert property (@(posedge clk) disable iff (rst)
        (bus_o.op != CMD_NOP) |-> (int'(since_ref) >= TRFC)); // R6
    AST_RP_GAP: assert property (@(posedge clk) disable iff (rst)
        (bus_o.op == CMD_REF) |-> (int'(since_pre) >= TRP)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R6
endmodule

// File: rtl/ref_sched.sv
`timescale 1ns/1ps
module ref_sched
    import ref_pkg::*;
#(
    parameter int TREFI_NORM = 1950,
    parameter int TREFI_HOT  = 975,
    parameter int T_RP       = 4,
    parameter int T_RFC      = 32,
    parameter int MAX_PEND   = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hot_i,
    input  logic       bank_open_i,
    input  logic       gnt_i,
    output logic       req_o,
    output logic       urgent_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [1:0] cmd_o,
    output logic       a10_o,
    output logic       cke_o
);
    logic tick;
    bus_t bus;

    ref_tick #(.NORM(TREFI_NORM), .HOT(TREFI_HOT)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .hot_i  (hot_i),
        .tick_o (tick)
    );

    ref_pend #(.MAXP(MAX_PEND)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .inc_i  (tick),
        .dec_i  (done_o),
        .nz_o   (req_o),
        .full_o (urgent_o)
    );

    ref_seq #(.TRP(T_RP), .TRFC(T_RFC)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .owed_i      (req_o),
        .gnt_i       (gnt_i),
        .bank_open_i (bank_open_i),
        .bus_o       (bus),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    assign cmd_o = bus.op;
    assign a10_o = bus.a10;
    assign cke_o = 1'b1;

    AST_URGENT_REQ: assert property (@(posedge clk) disable iff (rst)
        urgent_o |-> req_o); // R7
endmodule

// File: tb/sim_ref_sched.sv
`timescale 1ns/1ps
module sim_ref_sched;
    localparam int NORM = 200;
    localparam int HOT  = 100;
    localparam int TRP  = 3;
    localparam int TRFC = 10;
    localparam int MAXP = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hot = 1'b0, bank = 1'b0, gnt = 1'b0;
    logic req, urg, busy, done, a10, cke;
    logic [1:0] cmd;

    always #2 clk = ~clk;

    ref_sched #(.TREFI_NORM(NORM), .TREFI_HOT(HOT), .T_RP(TRP),
                .T_RFC(TRFC), .MAX_PEND(MAXP)) u0 (
        .clk(clk), .rst(rst), .hot_i(hot), .bank_open_i(bank), .gnt_i(gnt),
        .req_o(req), .urgent_o(urg), .busy_o(busy), .done_o(done),
        .cmd_o(cmd), .a10_o(a10), .cke_o(cke));

    int vec = 0, bad = 0;
    int cyc = 0;
    bit finished = 0;

    // requirement-level model: 0 idle,1 pre,2 rp wait,3 ref,4 rfc wait
    int m_cnt, m_pend, m_st, m_w;

    function automatic int exp_cmd(int st);
        return (st == 1) ? 1 : (st == 3) ? 2 : 0;
    endfunction
    function automatic bit exp_done(int st, int w);
        return (st == 4) && (w == 1);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_cnt = NORM - 1; m_pend = 0; m_st = 0; m_w = 0;
        end else begin
            bit tk, dn;
            tk = (m_cnt == 0);
            dn = exp_done(m_st, m_w);
            m_cnt = tk ? ((hot ? HOT : NORM) - 1) : m_cnt - 1;
            case (m_st)
                0: if (gnt && m_pend != 0) m_st = bank ? 1 : 3;
                1: begin m_st = 2; m_w = TRP - 1; end
                2: if (m_w == 1) m_st = 3; else m_w--;
                3: begin m_st = 4; m_w = TRFC - 1; end
                default: if (m_w == 1) m_st = 0; else m_w--;
            endcase
            if (tk && !dn && m_pend < MAXP) m_pend++;
            else if (dn && !tk) m_pend--;
        end
    end

    task automatic chk(bit ok, string r, int act, int expv);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cycle %0d: got %0d expected %0d", r, cyc, act, expv);
        end
    endtask

    int last_ref = -1000, last_pre = -1000;
    bit pre_open = 0, saw_urg = 0, saw_pre = 0;

    task automatic compare_all();
        chk(int'(cmd) == exp_cmd(m_st), "R4", int'(cmd), exp_cmd(m_st));
        chk(a10 == (m_st == 1), "R5", int'(a10), int'(m_st == 1));
        chk(done == exp_done(m_st, m_w), "R6", int'(done), int'(exp_done(m_st, m_w)));
        chk(busy == (m_st != 0), "R6", int'(busy), int'(m_st != 0));
        chk(req == (m_pend != 0), hot ? "R3" : "R2", int'(req), int'(m_pend != 0));
        chk(urg == (m_pend == MAXP), "R7", int'(urg), int'(m_pend == MAXP));
        chk(cke == 1'b1, "R9", int'(cke), 1);
        if (urg) saw_urg = 1;
        if (cmd == 2'b01) begin last_pre = cyc; pre_open = 1; saw_pre = 1; end
        if (cmd == 2'b10) begin
            chk(cyc - last_ref >= TRFC, "R8", cyc - last_ref, TRFC);
            if (pre_open) chk(cyc - last_pre == TRP, "R5", cyc - last_pre, TRP);
            pre_open = 0;
            last_ref = cyc;
        end
    endtask

    task automatic step(bit g, bit b, bit h);
        @(posedge clk);
        @(negedge clk);
        compare_all();
        gnt = g; bank = b; hot = h;
    endtask

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cmd == 2'b00 && !req && !urg && !busy && !done && !a10 && cke,
            "R1", {cmd, req, urg, busy, done, a10, cke}, 7'b0000001);
        rst = 1'b0;
        gnt = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(cmd == 2'b00 && !req && !busy && cke, "R1", int'(cmd), 0);
        compare_all();
        // R10: grant held while nothing owed
        for (int i = 0; i < NORM - 10; i++) begin
            step(1'b1, 1'b1, 1'b0);
            chk(cmd == 2'b00 && !busy, "R10", int'(cmd), 0);
        end
        // R2: first expiry sets req exactly NORM edges after release
        while (!req) step(1'b0, 1'b0, 1'b0);
        chk(cyc == NORM + 3, "R2", cyc, NORM + 3);
        // R7: stall the arbiter until the owed count saturates
        for (int i = 0; i < 10 * NORM; i++) step(1'b0, 1'b0, 1'b0);
        chk(urg == 1'b1, "R7", int'(urg), 1);
        // R8: drain back to back with grant held
        for (int i = 0; i < 12 * (TRFC + 2); i++) step(1'b1, 1'b0, 1'b0);
        // R3: hot interval with grant low
        for (int i = 0; i < 6 * HOT; i++) step(1'b0, 1'b0, 1'b1);
        // random mix
        for (int i = 0; i < 30000; i++) begin
            bit g, b, h;
            g = (m_st != 0) ? 1'b1 : (($urandom % 5) == 0);
            b = ($urandom % 2) == 1;
            h = ((i / 3000) % 2) == 1;
            step(g, b, h);
        end
        chk(saw_urg, "R7", int'(saw_urg), 1);
        chk(saw_pre, "R5", int'(saw_pre), 1);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            vec++; bad++;
            $display("FAIL watchdog cycle %0d: got 0 expected 1", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end
endmodule